// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of an SDRAM burst, as the internal column counter of a memory device or a controller model would. A start strobe captures a starting column, a burst length code and a burst ordering. From the next cycle the block presents one column per clock, together with a beat-valid flag and a flag that marks the final beat. Finite bursts of 2, 4 or 8 beats keep their upper column bits fixed and wrap inside a window aligned to the burst length. Within that window the order is either sequential, which adds the beat index modulo the length, or interleaved, which XORs the beat index into the low bits. Full-page mode walks through all 2^COL_W columns in sequential order, wraps past the top column and continues until a stop strobe or a new start arrives.

The control is a three-state machine. `ST_IDLE` produces no beats. `ST_BURST` runs a finite burst. `ST_PAGE` runs a full-page burst. The transitions are:
- *launch*: from any state to `ST_BURST` or `ST_PAGE` on a start.
- *finish*: from `ST_BURST` to `ST_IDLE` after the final beat.
- *halt*: from `ST_BURST` or `ST_PAGE` to `ST_IDLE` on a stop.
- *advance*: stays in `ST_BURST` or `ST_PAGE` and steps the beat index.

A start that arrives during a burst is a launch, so it restarts generation from the new column.

Top module: `col_burst_gen`

## Requirements
- R1: While reset is held and after its release, `beat_vld_o` and `last_o` are 0 and `col_o` is 0 until the first start.
- R2: A start sampled at a clock edge makes `beat_vld_o` 1 from the next cycle, and beat 0 presents exactly `col_i` as captured at that edge.
- R3: The length code `len_i` is decoded as follows: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page. The reserved codes 3'b100, 3'b101 and 3'b110 give 1 beat.
- R4: With `ilv_i`=0 and length N of 2, 4 or 8, beat i presents {start[7:log2N], (start[log2N-1:0]+i) mod N}.
- R5: With `ilv_i`=1 and length N of 2, 4 or 8, beat i presents {start[7:log2N], start[log2N-1:0] XOR i}.
- R6: A full-page burst ignores `ilv_i`, steps the column by +1 each cycle, wraps from 255 to 0, and keeps running past 256 beats.
- R7: In a finite burst, `last_o` is 1 exactly on beat N-1. When no new start arrives, `beat_vld_o` is 0 in the following cycle.
- R8: `last_o` is never 1 during a full-page burst, and it is never 1 while `beat_vld_o` is 0.
- R9: A start during a burst restarts it at the new column in the next cycle. A start outranks a stop sampled at the same edge.
- R10: A stop sampled at an edge with no start ends the burst, including a full-page burst, so `beat_vld_o` is 0 in the next cycle.
- R11: `col_i`, `len_i` and `ilv_i` are used only at a start. Changing them during a burst leaves the remaining beats unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start or restart a burst at `col_i` |
| stop_i | input | 1 | End the current burst |
| col_i | input | COL_W (8) | Starting column |
| len_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 selects interleaved order, 0 selects sequential |
| col_o | output | COL_W (8) | Column of the current beat |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Final beat of a finite burst |

## Verification
The embedded properties assume that start and stop are sampled only at rising edges. They also assume that the state registers stay unchanged between a start and the next start or end, so the upper column bits of a running burst are expected to stay fixed. The stimulus drives every input one nanosecond after a rising edge. It holds start and stop high for exactly one cycle each. In every non-start cycle of a burst it fills `col_i`, `len_i` and `ilv_i` with random values, which exercises the rule that these inputs count only at a start. Bursts are ended naturally, by stop, by a start-and-stop collision, or by a restart, so every transition of the state machine is taken.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } gen_state_e;

    localparam logic [2:0] LEN_1    = 3'b000;
    localparam logic [2:0] LEN_2    = 3'b001;
    localparam logic [2:0] LEN_4    = 3'b010;
    localparam logic [2:0] LEN_8    = 3'b011;
    localparam logic [2:0] LEN_PAGE = 3'b111;

endpackage

// File: rtl/blen_decode.sv
module blen_decode #(
    parameter int COL_W = 8
) (
    input  logic [2:0]       len_code,
    output logic [COL_W-1:0] win_mask,
    output logic             is_page
);
    import burst_pkg::*;

    logic       finite_code;
    logic [1:0] log_len;

    always_comb begin
        is_page     = (len_code == LEN_PAGE);
        finite_code = (len_code[2] == 1'b0);
        log_len     = finite_code ? len_code[1:0] : 2'd0;
    end

    // Window mask: low log2(N) bits set, all bits for full page.
    for (genvar g = 0; g < COL_W; g++) begin : g_mask
        assign win_mask[g] = is_page | (32'(g) < 32'(log_len));
    end

endmodule

// File: rtl/col_order.sv
module col_order #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat_idx,
    input  logic [COL_W-1:0] win_mask,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] xor_low;

    always_comb begin
        seq_low = (base_col + beat_idx) & win_mask;
        xor_low = (base_col ^ beat_idx) & win_mask;
        col     = (base_col & ~win_mask) | (interleave ? xor_low : seq_low);
    end

endmodule

// File: rtl/col_burst_gen.sv
module col_burst_gen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [2:0]       len_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_vld_o,
    output logic             last_o
);
    import burst_pkg::*;

    gen_state_e       state_q, state_d;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] idx_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic [COL_W-1:0] ord_col;
    logic             at_end;

    blen_decode #(.COL_W(COL_W)) i_dec (
        .len_code (len_i),
        .win_mask (dec_mask),
        .is_page  (dec_page)
    );

    col_order #(.COL_W(COL_W)) i_ord (
        .base_col   (base_q),
        .beat_idx   (idx_q),
        .win_mask   (mask_q),
        .interleave (ilv_q),
        .col        (ord_col)
    );

    assign at_end = (idx_q == mask_q);

    // Next-state selection: launch, halt, finish, advance.
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = dec_page ? ST_PAGE : ST_BURST;
        end else if (stop_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BURST: state_d = at_end ? ST_IDLE : ST_BURST;
                ST_PAGE:  state_d = ST_PAGE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Burst context capture and beat index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
        end else if (start_i) begin
            base_q <= col_i;
            idx_q  <= '0;
            mask_q <= dec_mask;
            ilv_q  <= ilv_i & ~dec_page;
        end else if (state_q != ST_IDLE) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    // Output process.
    always_comb begin
        col_o      = '0;
        beat_vld_o = 1'b0;
        last_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                col_o      = '0;
            end
            ST_BURST: begin
                col_o      = ord_col;
                beat_vld_o = 1'b1;
                last_o     = at_end;
            end
            ST_PAGE: begin
                col_o      = ord_col;
                beat_vld_o = 1'b1;
            end
            default: begin
                col_o      = '0;
            end
        endcase
    end

    // R8
    last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_vld_o);

    // R8
    page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE) |-> !last_o);

    // R2
    start_gives_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (beat_vld_o && col_o == $past(col_i)));

    // R7
    end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !beat_vld_o);

    // R10
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !beat_vld_o);

    // R11
    window_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && !start_i && !stop_i && !last_o) |=>
        (beat_vld_o && ((col_o & ~mask_q) == ($past(col_o) & ~$past(mask_q)))));

    // R6
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE && !start_i && !stop_i) |=>
        (col_o == COL_W'($past(col_o) + 1'b1)));

endmodule

// File: tb/test_col_burst_gen.sv
`timescale 1ns/1ps
module test_col_burst_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] col_i = '0;
    logic [2:0] len_i = '0;
    logic       ilv_i = 1'b0;
    logic [7:0] col_o;
    logic       beat_vld_o;
    logic       last_o;

    always #2 clk = ~clk;

    col_burst_gen #(.COL_W(8)) i_col_burst_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .col_i      (col_i),
        .len_i      (len_i),
        .ilv_i      (ilv_i),
        .col_o      (col_o),
        .beat_vld_o (beat_vld_o),
        .last_o     (last_o)
    );

    typedef struct {
        int         cyc;
        logic       v;
        logic       l;
        logic [7:0] c;
        string      req;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Burst length per R3.
    function automatic int blen(input logic [2:0] code);
        case (code)
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return 256;
            default: return 1;
        endcase
    endfunction

    // Expected column per R4, R5, R6.
    function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [2:0] code,
                                           input logic ilv, input int i);
        int n = blen(code);
        logic [7:0] m;
        logic [7:0] ib = 8'(i);
        if (n == 256) return 8'(s + ib);
        m = 8'(n - 1);
        if (ilv) return (s & ~m) | ((s ^ ib) & m);
        return (s & ~m) | (8'(s + ib) & m);
    endfunction

    // Monitor: compares the scoreboard entry due this cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                e = q.pop_front();
                checks++;
                if (e.cyc != cyc) begin
                    fails++;
                    $display("FAIL %s: entry for cycle %0d missed, now %0d", e.req, e.cyc, cyc);
                end else if (beat_vld_o !== e.v || last_o !== e.l ||
                             (e.v && col_o !== e.c)) begin
                    fails++;
                    $display("FAIL %s: cyc %0d got v=%b l=%b c=%h exp v=%b l=%b c=%h",
                             e.req, cyc, beat_vld_o, last_o, col_o, e.v, e.l, e.c);
                end
            end
        end
    end

    // Driver: starts a burst, predicts its beats, scrambles unused inputs (R11).
    // endk: 0 = next call restarts it, 1 = stop, 2 = natural end.
    task automatic go(input logic [7:0] s, input logic [2:0] code, input logic ilv,
                      input int beats, input int endk, input bit stop_too, input string req);
        int k;
        int n = blen(code);
        exp_t x;
        @(posedge clk); #1;
        k = cyc;
        start_i = 1'b1; stop_i = stop_too; col_i = s; len_i = code; ilv_i = ilv;
        for (int i = 0; i < beats; i++) begin
            x.cyc = k + 1 + i;
            x.v = 1'b1;
            x.l = (n != 256) && (i == n - 1);
            x.c = exp_col(s, code, ilv, i);
            x.req = req;
            q.push_back(x);
        end
        for (int j = 1; j < beats; j++) begin
            @(posedge clk); #1;
            start_i = 1'b0; stop_i = 1'b0;
            col_i = 8'($urandom); len_i = 3'($urandom); ilv_i = 1'($urandom);
        end
        if (endk != 0) begin
            @(posedge clk); #1;
            start_i = 1'b0;
            stop_i = (endk == 1);
            col_i = 8'($urandom); len_i = 3'($urandom); ilv_i = 1'($urandom);
            x.cyc = cyc + 1; x.v = 1'b0; x.l = 1'b0; x.c = '0;
            x.req = (endk == 1) ? "R10" : "R7";
            q.push_back(x);
            @(posedge clk); #1;
            stop_i = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, got hang exp completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (beat_vld_o !== 1'b0 || last_o !== 1'b0 || col_o !== 8'h00) begin
            fails++;
            $display("FAIL R1: in reset got v=%b l=%b c=%h exp 0 0 00", beat_vld_o, last_o, col_o);
        end
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (beat_vld_o !== 1'b0 || last_o !== 1'b0 || col_o !== 8'h00) begin
            fails++;
            $display("FAIL R1: after reset got v=%b l=%b c=%h exp 0 0 00", beat_vld_o, last_o, col_o);
        end

        go(8'h3E, 3'b010, 1'b0, 4, 2, 0, "R4");     // 3E 3F 3C 3D
        go(8'h15, 3'b011, 1'b1, 8, 2, 0, "R5");     // XOR within 8
        go(8'hA7, 3'b011, 1'b0, 8, 2, 0, "R4");
        go(8'h91, 3'b001, 1'b0, 2, 2, 0, "R4");
        go(8'h91, 3'b001, 1'b1, 2, 2, 0, "R5");
        go(8'h6B, 3'b010, 1'b1, 4, 2, 0, "R5");
        go(8'h5A, 3'b000, 1'b1, 1, 2, 0, "R3");
        go(8'hC3, 3'b101, 1'b0, 1, 2, 0, "R3");     // reserved -> 1 beat
        go(8'hFC, 3'b111, 1'b1, 10, 1, 0, "R6");    // page, ilv ignored, stop R10
        go(8'h10, 3'b111, 1'b0, 300, 1, 0, "R8");   // page past 256 beats
        go(8'h2D, 3'b011, 1'b0, 5, 1, 0, "R10");    // stop mid burst
        go(8'h44, 3'b011, 1'b0, 3, 0, 0, "R9");     // interrupted by next start
        go(8'hB6, 3'b010, 1'b1, 2, 0, 0, "R9");     // interrupted again
        go(8'h0F, 3'b011, 1'b1, 8, 2, 1, "R9");     // start with stop: start wins
        go(8'h81, 3'b111, 1'b0, 4, 0, 0, "R9");     // page interrupted by start
        go(8'hE2, 3'b011, 1'b0, 8, 2, 0, "R11");

        repeat (6) @(posedge clk);
        @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d expected beats never compared, exp 0", q.size());
        end
        done = 1;
        report();
        $finish;
    end

endmodule